// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Bridge

This block lets boot code run straight out of a serial NOR flash. A host reads 32-bit words from a bus window. The bridge turns each read into a complete serial flash read on chip-select 0 and returns the word once all of its bits have arrived. The host does not manage any FIFO and does not drive the serial pins; it only waits for the response.

A small control register picks which side owns the serial pins. In register-access mode, a separate SPI master (its registers visible to software) drives the pins and the bridge stays idle. In direct-mapping mode, the bridge drives the pins and the master is cut off. The same register holds a 2-bit boot-source field.

The window is read-only. Writes, reads past the mapped flash length, and reads made while register access is enabled all complete at once with an error response. None of them touches the serial pins.

Top module: `flash_map_bridge`

## Requirements
- R1: After reset the control register reads 0x0002: bit 8 (register access) is 0, so direct mapping is active, and field [1:0] is 2 (boot from flash). Chip-select is high, SCK is low, and neither ack nor err is asserted.
- R2: The control register keeps register-access enable at bit 8 and the boot-source field at bits [1:0] (0 ROM, 1 SRAM, 2 flash). All other bits read as zero. A write updates both fields on the next clock.
- R3: An accepted read drives chip-select low and sends, MSB first, opcode 0x03 followed by the 24-bit byte address with its two low bits forced to zero. SCK idles low, the flash samples MOSI on the rising edge, and MOSI changes on the falling edge.
- R4: After the 32 command bits, the bridge samples 32 MISO bits on the rising SCK edges. The first received byte lands in bits [7:0] of the returned word and the fourth lands in bits [31:24].
- R5: `win_ack` stays low until the last data bit has been sampled. It then pulses high for one cycle, with `win_rdata` valid and chip-select already released. `win_ack` and `win_err` are never high together.
- R6: Each SCK half period lasts CLK_DIV clock cycles. Chip-select stays high for at least 2*CLK_DIV clock cycles (one SCK period) between two reads.
- R7: A write to the window produces `win_err` in the cycle after acceptance and causes no chip-select activity.
- R8: A read at a byte address at or above MAP_BYTES produces `win_err` and causes no chip-select activity.
- R9: While register access is enabled, window reads return `win_err`, and the serial pins follow `mst_sck`, `mst_cs_n` and `mst_mosi`, with `spi_miso` routed to `mst_miso`. While direct mapping is active, the master inputs have no effect on the pins.
- R10: A control-register write that arrives while a flash read is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Control register write strobe |
| csr_wdata | input | 16 | Control register write data |
| csr_rdata | output | 16 | Control register contents |
| win_req | input | 1 | Window access request, held until ack or err |
| win_we | input | 1 | Request is a write |
| win_addr | input | AW | Window byte address |
| win_ack | output | 1 | One-cycle read completion |
| win_err | output | 1 | One-cycle error completion |
| win_rdata | output | 32 | Returned flash word |
| mst_sck | input | 1 | SCK from the register-mode SPI master |
| mst_cs_n | input | 1 | Chip-select from the register-mode SPI master |
| mst_mosi | input | 1 | MOSI from the register-mode SPI master |
| mst_miso | output | 1 | MISO to the register-mode SPI master |
| spi_sck | output | 1 | Serial clock pin |
| spi_cs_n | output | 1 | Chip-select 0 pin, active low |
| spi_miso | input | 1 | Serial data from flash |
| spi_mosi | output | 1 | Serial data to flash |

## Verification
The bench builds the bridge with CLK_DIV = 2 and MAP_BYTES = 1024. The short SCK period keeps each 64-bit transaction to a few hundred cycles, so back-to-back reads and the chip-select gap between them are exercised many times. The small mapped length puts the last valid word (0x3FC) and the first refused address (0x400) within easy reach. A flash model on the serial pins returns bytes computed from the address, so it checks both the command bits and the byte packing.

// File: rtl/fmb_pkg.sv
package fmb_pkg;
    localparam int FLASH_AW   = 24;
    localparam int CMD_BITS   = 8 + FLASH_AW;
    localparam int DATA_BITS  = 32;
    localparam int XFER_BITS  = CMD_BITS + DATA_BITS;
    localparam int BIT_W      = $clog2(XFER_BITS);
    localparam int ACC_POS    = 8;
    localparam logic [7:0] OPC_READ = 8'h03;

    typedef enum logic [1:0] {
        S_IDLE,
        S_XFER,
        S_GAP
    } seq_state_e;

    typedef struct packed {
        logic       reg_access;
        logic [1:0] boot_src;
    } ctl_t;

    // first received byte sits in the top of the shift register
    function automatic logic [31:0] pack_le(input logic [31:0] sr);
        return {sr[7:0], sr[15:8], sr[23:16], sr[31:24]};
    endfunction

    function automatic logic [15:0] ctl_image(input ctl_t c);
        logic [15:0] v;
        v = '0;
        v[ACC_POS] = c.reg_access;
        v[1:0]     = c.boot_src;
        return v;
    endfunction
endpackage

// File: rtl/fmb_ctl.sv
module fmb_ctl
    import fmb_pkg::*;
#(
    parameter logic [1:0] BOOT_DEF = 2'd2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [15:0] wdata,
    input  logic        freeze,
    output logic [15:0] rdata,
    output logic        reg_access
);
    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.reg_access <= 1'b0;
            ctl_q.boot_src   <= BOOT_DEF;
        end else if (we && !freeze) begin
            ctl_q.reg_access <= wdata[ACC_POS];
            ctl_q.boot_src   <= wdata[1:0];
        end
    end

    assign rdata      = ctl_image(ctl_q);
    assign reg_access = ctl_q.reg_access;

    // R10
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        freeze |=> $stable(ctl_q));
endmodule

// File: rtl/fmb_seq.sv
module fmb_seq
    import fmb_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [FLASH_AW-1:0] addr,
    input  logic                miso,
    output logic                sck,
    output logic                cs_n,
    output logic                mosi,
    output logic                busy,
    output logic                done,
    output logic [31:0]         rdata
);
    localparam int GAP_CYC = 2 * CLK_DIV;
    localparam int CNT_W   = $clog2(GAP_CYC + 1);

    seq_state_e         state;
    logic [CNT_W-1:0]   div_cnt;
    logic [BIT_W-1:0]   bit_cnt;
    logic [CMD_BITS-1:0] tx_sr;
    logic [DATA_BITS-1:0] rx_sr;
    logic               sck_q, cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            sck_q   <= 1'b0;
            cs_q    <= 1'b1;
            done    <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    tx_sr   <= {OPC_READ, addr[FLASH_AW-1:2], 2'b00};
                    cs_q    <= 1'b0;
                    sck_q   <= 1'b0;
                    bit_cnt <= '0;
                    div_cnt <= '0;
                    state   <= S_XFER;
                end
                S_XFER: begin
                    if (div_cnt == CNT_W'(CLK_DIV - 1)) begin
                        div_cnt <= '0;
                        if (!sck_q) begin
                            sck_q <= 1'b1;
                            if (bit_cnt >= BIT_W'(CMD_BITS))
                                rx_sr <= {rx_sr[DATA_BITS-2:0], miso};
                        end else begin
                            sck_q <= 1'b0;
                            if (bit_cnt == BIT_W'(XFER_BITS - 1)) begin
                                cs_q  <= 1'b1;
                                done  <= 1'b1;
                                rdata <= pack_le(rx_sr);
                                state <= S_GAP;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                                tx_sr   <= {tx_sr[CMD_BITS-2:0], 1'b0};
                            end
                        end
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                S_GAP: begin
                    if (div_cnt == CNT_W'(GAP_CYC - 1)) begin
                        div_cnt <= '0;
                        state   <= S_IDLE;
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign sck  = sck_q;
    assign cs_n = cs_q;
    assign mosi = (state == S_XFER) && tx_sr[CMD_BITS-1];
    assign busy = (state != S_IDLE);

    // R3
    sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_q |-> !sck_q);
    // R6
    cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_GAP) |-> cs_q);
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R5
    done_full_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_q) |-> (done && bit_cnt == BIT_W'(XFER_BITS - 1)));
endmodule

// File: rtl/fmb_pinmux.sv
module fmb_pinmux (
    input  logic reg_access,
    input  logic eng_sck,
    input  logic eng_cs_n,
    input  logic eng_mosi,
    input  logic mst_sck,
    input  logic mst_cs_n,
    input  logic mst_mosi,
    output logic mst_miso,
    output logic spi_sck,
    output logic spi_cs_n,
    output logic spi_mosi,
    input  logic spi_miso
);
    always_comb begin
        if (reg_access) begin
            spi_sck  = mst_sck;
            spi_cs_n = mst_cs_n;
            spi_mosi = mst_mosi;
            mst_miso = spi_miso;
        end else begin
            spi_sck  = eng_sck;
            spi_cs_n = eng_cs_n;
            spi_mosi = eng_mosi;
            mst_miso = 1'b0;
        end
    end
endmodule

// File: rtl/flash_map_bridge.sv
module flash_map_bridge
    import fmb_pkg::*;
#(
    parameter int         AW        = 24,
    parameter int         MAP_BYTES = 65536,
    parameter int         CLK_DIV   = 4,
    parameter logic [1:0] BOOT_DEF  = 2'd2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          csr_we,
    input  logic [15:0]   csr_wdata,
    output logic [15:0]   csr_rdata,
    input  logic          win_req,
    input  logic          win_we,
    input  logic [AW-1:0] win_addr,
    output logic          win_ack,
    output logic          win_err,
    output logic [31:0]   win_rdata,
    input  logic          mst_sck,
    input  logic          mst_cs_n,
    input  logic          mst_mosi,
    output logic          mst_miso,
    output logic          spi_sck,
    output logic          spi_cs_n,
    input  logic          spi_miso,
    output logic          spi_mosi
);
    localparam logic [AW:0] MAP_LIM = (AW + 1)'(MAP_BYTES);

    logic reg_access, eng_busy, eng_done, err_q;
    logic eng_sck, eng_cs_n, eng_mosi;
    logic accept, refuse, start;

    assign accept = win_req && !eng_busy && !err_q;
    assign refuse = win_we || reg_access || ({1'b0, win_addr} >= MAP_LIM);
    assign start  = accept && !refuse;

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= accept && refuse;
    end

    fmb_ctl #(.BOOT_DEF(BOOT_DEF)) u_ctl (
        .clk(clk), .rst(rst), .we(csr_we), .wdata(csr_wdata),
        .freeze(eng_busy || start), .rdata(csr_rdata), .reg_access(reg_access)
    );

    fmb_seq #(.CLK_DIV(CLK_DIV)) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .addr(FLASH_AW'(win_addr)), .miso(spi_miso),
        .sck(eng_sck), .cs_n(eng_cs_n), .mosi(eng_mosi),
        .busy(eng_busy), .done(eng_done), .rdata(win_rdata)
    );

    fmb_pinmux u_mux (
        .reg_access(reg_access),
        .eng_sck(eng_sck), .eng_cs_n(eng_cs_n), .eng_mosi(eng_mosi),
        .mst_sck(mst_sck), .mst_cs_n(mst_cs_n), .mst_mosi(mst_mosi),
        .mst_miso(mst_miso),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    assign win_ack = eng_done;
    assign win_err = err_q;

    // R7
    write_err_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && win_we) |=> (win_err && eng_cs_n));
    // R5
    resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(win_ack && win_err));
    // R9
    regmode_idle_chk: assert property (@(posedge clk) disable iff (rst)
        reg_access |-> !eng_busy);
endmodule

// File: tb/sim_flash_map_bridge.sv
module sim_flash_map_bridge;
    localparam int AW = 24, MAPB = 1024, DIV = 2;

    logic clk = 0, rst = 1;
    logic csr_we = 0; logic [15:0] csr_wdata = 0; logic [15:0] csr_rdata;
    logic win_req = 0, win_we = 0; logic [AW-1:0] win_addr = 0;
    logic win_ack, win_err; logic [31:0] win_rdata;
    logic mst_sck = 0, mst_cs_n = 1, mst_mosi = 0, mst_miso;
    logic spi_sck, spi_cs_n, spi_mosi; logic spi_miso = 0;

    always #2.5 clk = ~clk;

    flash_map_bridge #(.AW(AW), .MAP_BYTES(MAPB), .CLK_DIV(DIV)) u0 (.*);

    int checks = 0, fails = 0;
    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input int a);
        return 8'((a ^ 8'hA5) + (a >> 8) * 3);
    endfunction

    // flash model
    int bitn = 0; logic [31:0] cmd_sr = 0, last_cmd = 0; int cs_falls = 0;
    int unsigned cyc = 0, rise_cyc = 0; bit seen_rise = 0;
    always @(posedge clk) cyc++;
    always @(negedge spi_cs_n) begin
        bitn = 0; cs_falls++;
        if (seen_rise) check("R6 cs gap", 64'(cyc - rise_cyc >= 2*DIV), 64'd1);
    end
    always @(posedge spi_cs_n) begin rise_cyc = cyc; seen_rise = 1; end
    always @(posedge spi_sck) if (!spi_cs_n) begin
        if (bitn < 32) cmd_sr = {cmd_sr[30:0], spi_mosi};
        bitn++;
        if (bitn == 32) last_cmd = cmd_sr;
    end
    always @(negedge spi_sck) if (!spi_cs_n && bitn >= 32 && bitn < 64) begin
        automatic int k = bitn - 32;
        automatic logic [7:0] b = fbyte(int'(last_cmd[23:0]) + k/8);
        spi_miso = b[7 - k%8];
    end

    // scoreboard
    bit q_err[$]; logic [31:0] q_data[$]; logic [31:0] q_cmd[$];
    always @(negedge clk) if (!rst && (win_ack || win_err)) begin
        if (q_err.size() == 0) check("R5 unexpected response", 64'd1, 64'd0);
        else begin
            automatic bit e = q_err.pop_front();
            automatic logic [31:0] d = q_data.pop_front();
            automatic logic [31:0] c = q_cmd.pop_front();
            check("R7 R8 response kind", 64'(win_err), 64'(e));
            if (!e) begin
                check("R3 command bits", 64'(last_cmd), 64'(c));
                check("R4 packed word", 64'(win_rdata), 64'(d));
                check("R5 cs released at ack", 64'(spi_cs_n), 64'd1);
            end
        end
    end

    task automatic access(input int a, input bit wr, input bit exp_err);
        automatic int al = a & ~3;
        q_err.push_back(exp_err);
        q_data.push_back({fbyte(al+3), fbyte(al+2), fbyte(al+1), fbyte(al)});
        q_cmd.push_back({8'h03, 24'(al)});
        win_addr = AW'(a); win_we = wr; win_req = 1;
        @(negedge clk);
        while (!(win_ack || win_err)) @(negedge clk);
        win_req = 0; win_we = 0;
    endtask

    task automatic csr_write(input logic [15:0] v);
        csr_wdata = v; csr_we = 1; @(negedge clk); csr_we = 0; @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk); rst = 0; @(negedge clk);
        // R1
        check("R1 csr reset", 64'(csr_rdata), 64'h0002);
        check("R1 cs_n", 64'(spi_cs_n), 64'd1);
        check("R1 sck", 64'(spi_sck), 64'd0);
        check("R1 no response", 64'({win_ack, win_err}), 64'd0);
        // R2
        csr_write(16'hFE01);
        check("R2 csr fields", 64'(csr_rdata), 64'h0001);
        csr_write(16'h0002);
        check("R2 csr restore", 64'(csr_rdata), 64'h0002);
        // R3 R4 R5 R6 reads, back to back
        access(0, 0, 0);
        access('h10, 0, 0);
        access('h3FD, 0, 0);   // unaligned -> 0x3FC, last word
        access('h1A4, 0, 0);
        // R8 out of range
        f0 = cs_falls;
        access('h400, 0, 1);
        access('h7FC, 0, 1);
        check("R8 no cs activity", 64'(cs_falls), 64'(f0));
        // R7 write
        access('h20, 1, 1);
        check("R7 no cs activity", 64'(cs_falls), 64'(f0));
        // R9 master inputs ignored in mapping mode
        mst_sck = 1; mst_cs_n = 0; mst_mosi = 1; @(negedge clk);
        check("R9 mapping ignores master", 64'({spi_sck, spi_cs_n}), 64'b01);
        // R9 register mode
        csr_write(16'h0102);
        check("R9 csr access bit", 64'(csr_rdata), 64'h0102);
        spi_miso = 1; @(negedge clk);
        check("R9 passthrough", 64'({spi_sck, spi_cs_n, spi_mosi, mst_miso}), 64'b1011);
        mst_sck = 0; mst_cs_n = 1; mst_mosi = 0; @(negedge clk);
        check("R9 passthrough low", 64'({spi_sck, spi_cs_n, spi_mosi}), 64'b010);
        f0 = cs_falls;
        access('h8, 0, 1);
        check("R9 read refused, no cs", 64'(cs_falls), 64'(f0));
        csr_write(16'h0002);
        // R10 write during a read is ignored
        fork
            access('h44, 0, 0);
            begin repeat (20) @(negedge clk); csr_write(16'h0101); end
        join
        check("R10 csr unchanged", 64'(csr_rdata), 64'h0002);
        access('h48, 0, 0);
        repeat (10) @(negedge clk);
        check("R5 queue drained", 64'(q_err.size()), 64'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule